// File: doc/BRIEF.md
# Rotating Hardware-Thread Context Ring

This block keeps the architectural state of a group of hardware threads in a closed chain of pipeline slices. Each slice holds one thread context: a valid bit, the thread number, a program counter, one data register and a few control flags. On every advancing clock edge each context moves one slice down the chain, and the slice chosen as the loop-back tap feeds slice 0 again. A thread therefore issues exactly one instruction per trip. Consecutive issue slots always belong to different threads, so changing threads costs no cycles. The ring length, which is the number of resident threads, is picked at start-up from a range bounded by two parameters. Slots beyond the number of real threads carry null threads that never change any state.

The instruction stream itself comes from outside. Each cycle the thread in slice 0 is shown on the issue outputs, and the environment returns a 2-bit operation and an immediate, which travel with the context. Slice 1 executes the operation and can raise a memory read request. Slice `MEM_STG` is the last memory stage: a read that is still unanswered when its thread reaches it freezes the whole ring until the reply arrives. Slice `MEM_STG+1` is the sequencer, which picks the next program counter from a zero-compare on the data register. A sync operation freezes its thread until a global sync-arrival pulse is seen.

Top module: `thr_ring`

## Requirements
- R1: After reset the ring is idle: `running`, `iss_valid`, `mem_req_valid` and `stall` are all 0, and the ring does not move until `start` is seen.
- R2: `start` while idle loads the ring. The length L is `cfg_len` clamped to [TMIN, TMAX], and the thread count T is `cfg_threads` clamped to at most L. Thread k is placed in slice k with PC 0. In the cycle after the load, slice 0 shows thread 0 with PC 0.
- R3: Each non-stalled running cycle moves the ring one slice. After n advances slice 0 holds thread (L − n) mod L. With plain operations, a thread's PC grows by exactly 1 per trip, which means once every L advancing cycles.
- R4: Slots with thread number ≥ T are null: `iss_valid` is 0 for them, and their operations (including loads) produce no memory request, no stall and no state change.
- R5: `start` while running is ignored. Length, thread count and rotation continue unchanged.
- R6: Operation encoding on `iss_op`: 0 = increment the data register, 1 = memory read into the data register, 2 = sync (freeze), 3 = branch to `iss_imm` if the data register is zero. Every operation except a taken branch sets the next PC to PC + 1.
- R7: A read issued from slice 0 raises `mem_req_valid` with the thread's number on `mem_req_tid` in the next cycle, and only in a cycle in which the ring advances.
- R8: If a read's thread sits in the last memory stage (two advances after issue) while `rsp_valid` is 0, then `stall` is 1 and the whole ring holds. In the cycle `rsp_valid` is 1, `rsp_data` is written to that thread's data register and the ring moves on.
- R9: After a sync has executed, the thread is frozen. Its later issues change neither PC nor data register and raise no memory request, until `sync_arrive` is seen. A pulse in the same cycle as the frozen thread's issue lets that instruction execute.
- R10: The branch compare sees data written by an earlier read: a read returning 0 followed by a branch makes the branch taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load the ring and begin running (idle only) |
| cfg_len | input | 4 | Requested ring length |
| cfg_threads | input | 4 | Requested number of real threads |
| sync_arrive | input | 1 | Global sync-arrival pulse, releases frozen threads |
| iss_op | input | 2 | Operation for the thread now in slice 0 |
| iss_imm | input | 8 | Branch target for the thread now in slice 0 |
| rsp_valid | input | 1 | Memory read reply present this cycle |
| rsp_data | input | 8 | Memory read reply data |
| iss_valid | output | 1 | Slice 0 holds a real thread while running |
| iss_tid | output | 4 | Thread number in slice 0 |
| iss_pc | output | 8 | Program counter of the thread in slice 0 |
| mem_req_valid | output | 1 | Memory read request from slice 1 |
| mem_req_tid | output | 4 | Thread number of the request |
| stall | output | 1 | Ring held for a missing read reply |
| running | output | 1 | Ring loaded and rotating |

## Verification
Issue outputs are registered, so an operation presented to the thread in slice 0 shows its effect on the PC only when that thread next reaches slice 0, L advancing cycles later. The bench model therefore applies each operation's effect at its issue and compares it against the following trip. The memory request is due one advancing cycle after issue, and the stall condition two advancing cycles after issue. `stall` is combinational on `rsp_valid`, so the bench drives inputs at the falling edge and compares slightly later in the same cycle. Stalled cycles do not count as advances in the model.

// File: rtl/thr_ring_pkg.sv
package thr_ring_pkg;
  parameter int unsigned PC_W   = 8;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned TID_W  = 4;

  typedef enum logic [1:0] {
    OP_INC  = 2'd0,
    OP_LD   = 2'd1,
    OP_SYNC = 2'd2,
    OP_BRZ  = 2'd3
  } op_e;

  typedef struct packed {
    logic              valid;   // real thread
    logic              issued;  // instruction captured at slice 0 this trip
    logic              blk;     // this trip's instruction is suppressed
    logic              frozen;  // waiting for sync arrival
    logic              pend;    // read outstanding
    op_e               op;
    logic [TID_W-1:0]  tid;
    logic [PC_W-1:0]   pc;
    logic [PC_W-1:0]   imm;
    logic [DATA_W-1:0] acc;
  } ctx_t;
endpackage

// File: rtl/thr_ring_ctrl.sv
module thr_ring_ctrl #(
  parameter int TMAX  = 8,
  parameter int TMIN  = 4,
  parameter int LEN_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic [LEN_W-1:0] cfg_threads,
  input  logic             pend_mem,
  input  logic             rsp_valid,
  output logic             running,
  output logic             load_en,
  output logic [LEN_W-1:0] thr_cl,
  output logic [LEN_W-1:0] len_q,
  output logic [IDX_W-1:0] tap,
  output logic             stall,
  output logic             adv
);
  logic [LEN_W-1:0] len_cl;
  logic             run_q;
  logic             run_d;
  logic [LEN_W-1:0] len_d;

  always_comb begin
    if (cfg_len < LEN_W'(TMIN))      len_cl = LEN_W'(TMIN);
    else if (cfg_len > LEN_W'(TMAX)) len_cl = LEN_W'(TMAX);
    else                             len_cl = cfg_len;
    thr_cl  = (cfg_threads > len_cl) ? len_cl : cfg_threads;
    load_en = start & ~run_q;
    run_d   = run_q | load_en;
    len_d   = load_en ? len_cl : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      len_q <= LEN_W'(TMIN);
    end else if (load_en) begin
      run_q <= run_d;
      len_q <= len_d;
    end
  end

  assign running = run_q;
  assign tap     = IDX_W'(len_q - 1'b1);
  assign stall   = run_q & pend_mem & ~rsp_valid;
  assign adv     = run_q & ~stall;
endmodule

// File: rtl/thr_ring_stage.sv
module thr_ring_stage
  import thr_ring_pkg::*;
#(
  parameter int STAGE   = 0,
  parameter int MEM_STG = 2,
  parameter int SEQ_STG = 3
) (
  input  ctx_t              cur,
  input  op_e               op_in,
  input  logic [PC_W-1:0]   imm_in,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic              sync_arrive,
  output ctx_t              nxt
);
  logic live;

  always_comb begin
    nxt        = cur;
    live       = cur.issued & ~cur.blk;
    nxt.frozen = cur.frozen & ~sync_arrive;
    if (STAGE == 0) begin
      nxt.issued = cur.valid;
      nxt.blk    = cur.frozen & ~sync_arrive;
      nxt.op     = op_in;
      nxt.imm    = imm_in;
    end
    if (STAGE == 1 && live) begin
      if (cur.op == OP_INC) nxt.acc  = cur.acc + 1'b1;
      if (cur.op == OP_LD)  nxt.pend = 1'b1;
    end
    if (STAGE == MEM_STG && cur.pend && rsp_valid) begin
      nxt.acc  = rsp_data;
      nxt.pend = 1'b0;
    end
    if (STAGE == SEQ_STG && live) begin
      nxt.pc = (cur.op == OP_BRZ && cur.acc == '0) ? cur.imm : cur.pc + 1'b1;
      if (cur.op == OP_SYNC) nxt.frozen = 1'b1;
    end
  end
endmodule

// File: rtl/thr_ring.sv
module thr_ring
  import thr_ring_pkg::*;
#(
  parameter int TMAX    = 8,
  parameter int TMIN    = 4,
  parameter int MEM_STG = 2,
  parameter int LEN_W   = $clog2(TMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  cfg_threads,
  input  logic              sync_arrive,
  input  logic [1:0]        iss_op,
  input  logic [PC_W-1:0]   iss_imm,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              iss_valid,
  output logic [TID_W-1:0]  iss_tid,
  output logic [PC_W-1:0]   iss_pc,
  output logic              mem_req_valid,
  output logic [TID_W-1:0]  mem_req_tid,
  output logic              stall,
  output logic              running
);
  localparam int IDX_W   = $clog2(TMAX);
  localparam int SEQ_STG = MEM_STG + 1;

  ctx_t             ctx_q [TMAX];
  ctx_t             ctx_d [TMAX];
  ctx_t             nxt   [TMAX];
  logic             load_en, adv, ring_en, pend_mem;
  logic [LEN_W-1:0] thr_cl, len_q;
  logic [IDX_W-1:0] tap_q;

  assign pend_mem = ctx_q[MEM_STG].valid & ctx_q[MEM_STG].pend;

  thr_ring_ctrl #(.TMAX(TMAX), .TMIN(TMIN), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_threads(cfg_threads), .pend_mem(pend_mem), .rsp_valid(rsp_valid),
    .running(running), .load_en(load_en), .thr_cl(thr_cl), .len_q(len_q),
    .tap(tap_q), .stall(stall), .adv(adv)
  );

  for (genvar g = 0; g < TMAX; g++) begin : g_slice
    thr_ring_stage #(.STAGE(g), .MEM_STG(MEM_STG), .SEQ_STG(SEQ_STG)) u_stage (
      .cur(ctx_q[g]), .op_in(op_e'(iss_op)), .imm_in(iss_imm),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sync_arrive(sync_arrive),
      .nxt(nxt[g])
    );
  end

  assign ring_en = load_en | adv | (running & sync_arrive);

  always_comb begin
    for (int j = 0; j < TMAX; j++) begin
      ctx_d[j] = ctx_q[j];
      if (load_en) begin
        ctx_d[j]       = '0;
        ctx_d[j].valid = (LEN_W'(j) < thr_cl);
        ctx_d[j].tid   = TID_W'(j);
      end else if (adv) begin
        if (LEN_W'(j) >= len_q) ctx_d[j] = '0;
        else ctx_d[j] = nxt[(j == 0) ? tap_q : IDX_W'(j - 1)];
      end else begin
        ctx_d[j].frozen = ctx_q[j].frozen & ~sync_arrive;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < TMAX; j++) ctx_q[j] <= '0;
    end else if (ring_en) begin
      for (int j = 0; j < TMAX; j++) ctx_q[j] <= ctx_d[j];
    end
  end

  assign iss_valid     = running & ctx_q[0].valid;
  assign iss_tid       = ctx_q[0].tid;
  assign iss_pc        = ctx_q[0].pc;
  assign mem_req_valid = adv & ctx_q[1].issued & ~ctx_q[1].blk & (ctx_q[1].op == OP_LD);
  assign mem_req_tid   = ctx_q[1].tid;
endmodule

// File: rtl/thr_ring_chk.sv
module thr_ring_chk #(
  parameter int TID_W = 4,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             stall,
  input logic             iss_valid,
  input logic [TID_W-1:0] iss_tid,
  input logic [7:0]       iss_pc,
  input logic             mem_req_valid,
  input logic [IDX_W-1:0] tap
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!iss_valid && !mem_req_valid && !stall));

  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !stall) |=> (iss_tid == (($past(iss_tid) == '0) ?
                             TID_W'($past(tap)) : $past(iss_tid) - 1'b1)));

  p_tap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(tap));

  p_req_not_stalled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (running && !stall));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(iss_tid) && $stable(iss_pc)));

  p_stall_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> running);
endmodule

bind thr_ring thr_ring_chk #(.TID_W(thr_ring_pkg::TID_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .stall(stall),
  .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_pc(iss_pc),
  .mem_req_valid(mem_req_valid), .tap(tap_q)
);

// File: tb/thr_ring_tb.sv
`timescale 1ns/1ps
module thr_ring_tb;
  localparam int TMAX = 8;
  localparam int TMIN = 4;

  logic       clk = 1'b0;
  logic       rst_n, start, sync_arrive, rsp_valid;
  logic [3:0] cfg_len, cfg_threads;
  logic [1:0] iss_op;
  logic [7:0] iss_imm, rsp_data;
  logic       iss_valid, mem_req_valid, stall, running;
  logic [3:0] iss_tid, mem_req_tid;
  logic [7:0] iss_pc;

  always #2.5 clk = ~clk;

  thr_ring #(.TMAX(TMAX), .TMIN(TMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
    .cfg_threads(cfg_threads), .sync_arrive(sync_arrive), .iss_op(iss_op),
    .iss_imm(iss_imm), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .iss_valid(iss_valid), .iss_tid(iss_tid), .iss_pc(iss_pc),
    .mem_req_valid(mem_req_valid), .mem_req_tid(mem_req_tid),
    .stall(stall), .running(running)
  );

  int errors = 0, checks = 0, cyc = 0;
  // bench model
  int L, T, pos, scn, mem_wait, wait_cnt, ld_tid;
  bit run_m, post_ign, start_req;
  int req_len, req_thr;
  int pcm[TMAX], accm[TMAX], cntm[TMAX];
  bit frz[TMAX];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic int op_for(int t, int c);
    if (t >= T) return 1;                   // null slot gets a read: must be gated (R4)
    if (scn == 0) return 0;
    case (t)
      0: return (c == 1) ? 1 : 0;
      1: return (c == 1) ? 2 : (c == 2) ? 1 : 0;
      2: return (c == 1 || c == 3) ? 3 : (c == 2) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic cycle();
    int  tid_e, op;
    bit  val_e, exp_stall, exp_req, adv;
    string tg;
    @(negedge clk);
    tid_e = run_m ? ((L - (pos % L)) % L) : 0;
    val_e = run_m && (tid_e < T);
    start       = start_req;
    cfg_len     = 4'(req_len);
    cfg_threads = 4'(req_thr);
    if (mem_wait == 2 && wait_cnt >= 3) begin
      rsp_valid = 1'b1; rsp_data = (ld_tid == 2) ? 8'h00 : 8'h11;
    end else begin
      rsp_valid = 1'b0; rsp_data = 8'hEE;
    end
    sync_arrive = (scn == 1) && val_e && (tid_e == 1) && (cntm[1] == 4);
    op      = op_for(tid_e, cntm[tid_e]);
    iss_op  = 2'(op);
    iss_imm = 8'h30;
    #1;
    chk(running == run_m, "R2", "running", int'(running), int'(run_m));
    if (run_m) begin
      tg = (pos == 0) ? "R2" : post_ign ? "R5" : "R3";
      chk(int'(iss_tid) == tid_e, tg, "iss_tid", int'(iss_tid), tid_e);
      chk(iss_valid == val_e, "R4", "iss_valid", int'(iss_valid), int'(val_e));
      if (val_e) begin
        tg = frz[tid_e] ? "R9" : (scn == 1 && tid_e == 2) ? "R10" : (scn == 1) ? "R6" : "R3";
        chk(int'(iss_pc) == pcm[tid_e], tg, "iss_pc", int'(iss_pc), pcm[tid_e]);
      end
    end
    exp_stall = (mem_wait == 2) && !rsp_valid;
    exp_req   = run_m && (mem_wait == 1);
    chk(stall == exp_stall, "R8", "stall", int'(stall), int'(exp_stall));
    chk(mem_req_valid == exp_req, (scn == 1) ? "R7" : "R4", "mem_req_valid",
        int'(mem_req_valid), int'(exp_req));
    if (exp_req) chk(int'(mem_req_tid) == ld_tid, "R7", "mem_req_tid", int'(mem_req_tid), ld_tid);
    // model update for the coming edge
    adv = run_m && !exp_stall;
    if (sync_arrive) for (int k = 0; k < TMAX; k++) frz[k] = 1'b0;
    if (exp_stall) wait_cnt++;
    if (adv) begin
      if (mem_wait == 2) begin mem_wait = -1; wait_cnt = 0; end
      else if (mem_wait == 1) mem_wait = 2;
      if (val_e) begin
        if (!frz[tid_e]) begin
          case (op)
            0: begin accm[tid_e]++; pcm[tid_e]++; end
            1: begin
                 accm[tid_e] = (tid_e == 2) ? 0 : 17; pcm[tid_e]++;
                 mem_wait = 1; ld_tid = tid_e; wait_cnt = 0;
               end
            2: begin frz[tid_e] = 1'b1; pcm[tid_e]++; end
            default: pcm[tid_e] = (accm[tid_e] == 0) ? 'h30 : pcm[tid_e] + 1;
          endcase
        end
        cntm[tid_e]++;
      end
      pos++;
    end
    if (start_req && !run_m) begin
      run_m = 1'b1;
      L = clampi(req_len, TMIN, TMAX);
      T = (req_thr > L) ? L : req_thr;
      pos = 0;
    end else if (start_req && run_m) post_ign = 1'b1;
    start_req = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; sync_arrive = 1'b0; rsp_valid = 1'b0;
    rsp_data = '0; iss_op = '0; iss_imm = '0; cfg_len = '0; cfg_threads = '0;
    run_m = 1'b0; mem_wait = -1; wait_cnt = 0; ld_tid = 0; post_ign = 1'b0;
    start_req = 1'b0; L = TMIN; T = 0; pos = 0;
    for (int k = 0; k < TMAX; k++) begin pcm[k] = 0; accm[k] = 0; cntm[k] = 0; frz[k] = 1'b0; end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!running && !iss_valid && !mem_req_valid && !stall, "R1", "idle after reset",
        int'({running, iss_valid, mem_req_valid, stall}), 0);
  endtask

  task automatic run(int s, int cl, int ct, int ncyc, bit ign);
    do_reset();
    scn = s;
    cycle();                                  // idle cycle: ring must not move (R1)
    req_len = cl; req_thr = ct; start_req = 1'b1;
    cycle();
    for (int i = 0; i < ncyc; i++) begin
      if (ign && i == 5) begin
        start_req = 1'b1; req_len = TMIN; req_thr = 1;   // ignored while running (R5)
      end
      cycle();
    end
  endtask

  initial begin
    rst_n = 1'b0;
    for (int len = TMIN; len <= TMAX; len++)
      for (int thr = 0; thr <= len; thr++)
        run(0, len, thr, 3 * len + 4, thr == len);
    run(0, 2, 9, 14, 1'b0);    // clamp up to TMIN, threads clamped to length (R2)
    run(0, 15, 3, 20, 1'b0);   // clamp down to TMAX (R2)
    run(1, 5, 4, 60, 1'b0);    // loads, stalls, sync, branches (R6..R10)
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule